// File: doc/BRIEF.md
# Event Timer with One-Shot and Periodic Comparator

This block is a memory-mapped event timer. A 32-bit main counter advances by one on every clock while a global run bit is set. A single comparator channel watches the counter. When the two are equal, the channel sets a sticky status bit. While the channel is enabled, that status drives an interrupt line, one clock later.

The channel runs in one of two modes:
- **One-shot:** the comparator holds an absolute count and fires once.
- **Periodic:** on every match the comparator adds a stored period to itself, wrapping modulo 2^32, so the channel fires at a steady rate.

Software loads the periodic pair through an armed sequence. A configuration write with both the arm bit and the periodic bit set arms the channel. The first comparator write that follows sets the next match count, and the second sets the period.

The interrupt goes to one of several general lines, chosen by a route field in the channel configuration. When the legacy-routing bit in the global configuration is set, it goes instead to a dedicated legacy timer output.

Read-only registers report the number of channels and the legacy-routing capability, and the counter tick length in femtoseconds.

The bus is a single-cycle register port:
- A write takes effect at the clock edge where `bus_wr` is high.
- A read returns its data on `bus_rdata` after the edge where `bus_rd` is high. The data holds until the next read.

The register word indices are:

| Index | Register | Access |
|---|---|---|
| 0 | ID | read-only |
| 1 | tick length | read-only |
| 2 | global configuration | read/write |
| 3 | counter | read/write |
| 4 | counter upper word | reads zero |
| 5 | channel configuration | read/write |
| 6 | comparator | read/write |
| 7 | status | write 1 to clear |

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset:
  - the counter, the global configuration, the channel configuration, the period, the status and `bus_rdata` are all zero;
  - the comparator is all ones;
  - `irq_legacy` and every bit of `irq_lines` are low.
- R2: Index 0 reads 0x0000_8000: bits [4:0] hold the channel count minus one (0), and bit 15 flags that legacy routing is supported. Index 1 reads the tick-length parameter (69841279 by default). Writes to either index change neither value.
- R3: The counter at index 3 behaves as follows:
  - it rises by exactly 1 per clock while global configuration bit 0 (run) is 1;
  - it holds while run is 0;
  - a bus write to index 3 loads the written value, and this wins over the increment.
- R4: A match is a clock where run is 1 and the counter equals the comparator. A match sets status bit 0 (index 7) at that edge. In one-shot mode (channel configuration bit 1 clear) the comparator keeps its value, so no further match occurs until the counter wraps.
- R5: In periodic mode (channel configuration bit 1 set), a match adds the stored period to the comparator at the same edge, modulo 2^32. A bus write to the comparator in that cycle wins.
- R6: The armed load sequence works as follows:
  - A channel configuration write with bit 2 and bit 1 both set arms the load, and bit 2 then reads 1.
  - The next comparator write loads the match count, and bit 2 stays 1.
  - The write after that loads the period, and bit 2 reads 0.
  - Any channel configuration write without both bits clears the arming.
  - A comparator write while unarmed loads only the match count.
- R7: Writing 1 to status bit 0 clears it. A match in the same cycle keeps it set.
- R8: The interrupt outputs are registered and reflect status AND channel enable (channel configuration bit 0) one clock after status changes. With enable clear, no interrupt appears and the counter keeps running.
- R9: The interrupt is steered by global configuration bit 1 (legacy):
  - With legacy set, the interrupt appears on `irq_legacy` and `irq_lines` is all zero.
  - With legacy clear, it appears only on `irq_lines[route]`, where route is channel configuration bits [6:4], and `irq_legacy` is low.
- R10: Index 4 reads zero and ignores writes. Channel configuration bit 3 always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held between reads |
| irq_legacy | output | 1 | Legacy timer interrupt |
| irq_lines | output | 8 | General interrupt lines, selected by the route field |

## Verification
A corrupted counter, comparator or period shows up at the ports in one of two ways:
- **Timing:** an interrupt fires on the wrong clock, which is visible two edges after the faulty match.
- **Register values:** an index 3 or 6 read returns the wrong value on the cycle after the read strobe.

The bench runs a reference model in lockstep and compares the read data and both interrupt outputs on every clock. A wrong arming state therefore first appears as a wrong bit 2 in the channel configuration, and then as a period taking the place of a match count or the reverse, visible at the next match. Wraparound of the periodic comparator and set-versus-clear collisions on the status bit are driven on purpose, so that errors in those rare paths surface within a few dozen cycles.

// File: rtl/ett_pkg.sv
package ett_pkg;
  localparam int NUM_CH      = 1;
  localparam int ID_LEG_BIT  = 15;
  localparam int ROUTE_LSB   = 4;

  localparam logic [2:0] A_ID    = 3'd0;
  localparam logic [2:0] A_TICK  = 3'd1;
  localparam logic [2:0] A_GCFG  = 3'd2;
  localparam logic [2:0] A_CNT   = 3'd3;
  localparam logic [2:0] A_CNTHI = 3'd4;
  localparam logic [2:0] A_CCFG  = 3'd5;
  localparam logic [2:0] A_CMP   = 3'd6;
  localparam logic [2:0] A_STS   = 3'd7;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_CMP  = 2'd1,
    LD_PER  = 2'd2
  } ld_state_e;
endpackage

// File: rtl/ett_counter.sv
module ett_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run)  cnt <= cnt + DW'(1);
  end
endmodule

// File: rtl/ett_channel.sv
module ett_channel
  import ett_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] cnt,
  input  logic          cfg_wr,
  input  logic          cfg_en,
  input  logic          cfg_per,
  input  logic          cfg_arm,
  input  logic [RW-1:0] cfg_route,
  input  logic          cmp_wr,
  input  logic [DW-1:0] wdata,
  input  logic          sts_clr,
  output logic          en,
  output logic          per_mode,
  output logic          armed,
  output logic [RW-1:0] route,
  output logic [DW-1:0] cmp,
  output logic [DW-1:0] period,
  output logic          sts,
  output logic          match
);
  ld_state_e ld_q;

  assign match = run && (cnt == cmp);
  assign armed = (ld_q != LD_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      per_mode <= 1'b0;
      route    <= '0;
      ld_q     <= LD_IDLE;
    end else if (cfg_wr) begin
      en       <= cfg_en;
      per_mode <= cfg_per;
      route    <= cfg_route;
      ld_q     <= (cfg_arm && cfg_per) ? LD_CMP : LD_IDLE;
    end else if (cmp_wr) begin
      ld_q     <= (ld_q == LD_CMP) ? LD_PER : LD_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp    <= '1;
      period <= '0;
    end else if (cmp_wr && !cfg_wr) begin
      if (ld_q == LD_PER) period <= wdata;
      else                cmp    <= wdata;
    end else if (match && per_mode) begin
      cmp <= cmp + period;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          sts <= 1'b0;
    else if (match)   sts <= 1'b1;
    else if (sts_clr) sts <= 1'b0;
  end
endmodule

// File: rtl/ett_irq_route.sv
module ett_irq_route #(
  parameter int NLINES = 8,
  parameter int RW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              legacy,
  input  logic [RW-1:0]     route,
  output logic              irq_legacy,
  output logic [NLINES-1:0] irq_lines
);
  always_ff @(posedge clk) begin
    if (rst) irq_legacy <= 1'b0;
    else     irq_legacy <= fire && legacy;
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq_lines[g] <= 1'b0;
      else     irq_lines[g] <= fire && !legacy && (route == RW'(g));
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import ett_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NLINES  = 8,
  parameter int TICK_FS = 69841279
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_legacy,
  output logic [NLINES-1:0] irq_lines
);
  localparam int RW = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam logic [DW-1:0] ID_VAL = (DW'(1) << ID_LEG_BIT) | DW'(NUM_CH - 1);

  logic          run_q, legacy_q;
  logic          cnt_wr, cfg_wr, cmp_wr, sts_clr;
  logic [DW-1:0] cnt;
  logic          en, per_mode, armed, sts, match;
  logic [RW-1:0] route;
  logic [DW-1:0] cmp, period;
  logic [DW-1:0] ccfg_rd;

  assign cnt_wr  = bus_wr && (bus_addr == A_CNT);
  assign cfg_wr  = bus_wr && (bus_addr == A_CCFG);
  assign cmp_wr  = bus_wr && (bus_addr == A_CMP);
  assign sts_clr = bus_wr && (bus_addr == A_STS) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      legacy_q <= 1'b0;
    end else if (bus_wr && (bus_addr == A_GCFG)) begin
      run_q    <= bus_wdata[0];
      legacy_q <= bus_wdata[1];
    end
  end

  ett_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .load(cnt_wr),
    .load_val(bus_wdata), .cnt(cnt)
  );

  ett_channel #(.DW(DW), .RW(RW)) u_ch0 (
    .clk(clk), .rst(rst), .run(run_q), .cnt(cnt),
    .cfg_wr(cfg_wr), .cfg_en(bus_wdata[0]), .cfg_per(bus_wdata[1]),
    .cfg_arm(bus_wdata[2]), .cfg_route(bus_wdata[ROUTE_LSB +: RW]),
    .cmp_wr(cmp_wr), .wdata(bus_wdata), .sts_clr(sts_clr),
    .en(en), .per_mode(per_mode), .armed(armed), .route(route),
    .cmp(cmp), .period(period), .sts(sts), .match(match)
  );

  ett_irq_route #(.NLINES(NLINES), .RW(RW)) u_route (
    .clk(clk), .rst(rst), .fire(sts && en), .legacy(legacy_q),
    .route(route), .irq_legacy(irq_legacy), .irq_lines(irq_lines)
  );

  always_comb begin
    ccfg_rd                 = '0;
    ccfg_rd[0]              = en;
    ccfg_rd[1]              = per_mode;
    ccfg_rd[2]              = armed;
    ccfg_rd[3]              = 1'b1;
    ccfg_rd[ROUTE_LSB +: RW] = route;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_ID:    bus_rdata <= ID_VAL;
        A_TICK:  bus_rdata <= DW'(TICK_FS);
        A_GCFG:  bus_rdata <= {{(DW-2){1'b0}}, legacy_q, run_q};
        A_CNT:   bus_rdata <= cnt;
        A_CNTHI: bus_rdata <= '0;
        A_CCFG:  bus_rdata <= ccfg_rd;
        A_CMP:   bus_rdata <= cmp;
        default: bus_rdata <= {{(DW-1){1'b0}}, sts};
      endcase
    end
  end
endmodule

// File: rtl/evt_timer_checker.sv
module evt_timer_checker #(
  parameter int DW     = 32,
  parameter int NLINES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              cnt_wr,
  input logic [DW-1:0]     cnt,
  input logic              match,
  input logic              per_mode,
  input logic              cmp_wr,
  input logic [DW-1:0]     cmp,
  input logic [DW-1:0]     period,
  input logic              sts,
  input logic              fire,
  input logic              irq_legacy,
  input logic [NLINES-1:0] irq_lines
);
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_wr) |=> (cnt == $past(cnt) + DW'(1)));

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));

  p_match_sets_r4: assert property (@(posedge clk) disable iff (rst)
    match |=> sts);

  p_oneshot_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (match && !per_mode && !cmp_wr) |=> $stable(cmp));

  p_periodic_adv_r5: assert property (@(posedge clk) disable iff (rst)
    (match && per_mode && !cmp_wr) |=> (cmp == $past(cmp) + $past(period)));

  p_irq_needs_fire_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_legacy || (|irq_lines)) |-> $past(fire));

  p_lines_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_lines));

  p_legacy_excl_r9: assert property (@(posedge clk) disable iff (rst)
    irq_legacy |-> (irq_lines == '0));
endmodule

bind evt_timer evt_timer_checker #(.DW(DW), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst(rst), .run(run_q), .cnt_wr(cnt_wr), .cnt(cnt),
  .match(match), .per_mode(per_mode), .cmp_wr(cmp_wr), .cmp(cmp),
  .period(period), .sts(sts), .fire(sts && en),
  .irq_legacy(irq_legacy), .irq_lines(irq_lines)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam int CLK_NS = 10;
  localparam int DW     = 32;
  localparam int NL     = 8;
  localparam int TICK   = 69841279;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_legacy;
  logic [NL-1:0] irq_lines;

  evt_timer #(.DW(DW), .NLINES(NL), .TICK_FS(TICK)) u_evt_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_legacy(irq_legacy), .irq_lines(irq_lines)
  );

  always #(CLK_NS/2) clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    seen_leg = 0;
  int    seen_lines = 0;

  // behavioural reference model
  logic [31:0] m_cnt, m_cmp, m_per, m_rdata;
  bit          m_run, m_leg, m_en, m_pm, m_sts, m_irql;
  logic [2:0]  m_route;
  int          m_ld;
  logic [7:0]  m_lines;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return 32'h0000_8000;
      3'd1: return 32'(TICK);
      3'd2: return {30'd0, m_leg, m_run};
      3'd3: return m_cnt;
      3'd4: return 32'd0;
      3'd5: return {25'd0, m_route, 1'b1, (m_ld != 0), m_pm, m_en};
      3'd6: return m_cmp;
      default: return {31'd0, m_sts};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = '1; m_per = 0; m_rdata = 0;
      m_run = 0; m_leg = 0; m_en = 0; m_pm = 0; m_sts = 0; m_irql = 0;
      m_route = 0; m_ld = 0; m_lines = 0;
    end else begin
      bit          hit;
      bit          fire;
      logic [31:0] nxt_rd;
      hit    = m_run && (m_cnt == m_cmp);
      fire   = m_sts && m_en;
      nxt_rd = bus_rd ? m_read(bus_addr) : m_rdata;
      m_irql  = fire && m_leg;
      m_lines = (fire && !m_leg) ? (8'd1 << m_route) : 8'd0;
      if (hit) m_sts = 1;
      else if (bus_wr && bus_addr == 3'd7 && bus_wdata[0]) m_sts = 0;
      if (bus_wr && bus_addr == 3'd6) begin
        if (m_ld == 2) begin m_per = bus_wdata; m_ld = 0; end
        else begin m_cmp = bus_wdata; m_ld = (m_ld == 1) ? 2 : 0; end
      end else if (hit && m_pm) begin
        m_cmp = m_cmp + m_per;
      end
      if (bus_wr && bus_addr == 3'd3) m_cnt = bus_wdata;
      else if (m_run) m_cnt = m_cnt + 1;
      if (bus_wr && bus_addr == 3'd2) begin
        m_run = bus_wdata[0]; m_leg = bus_wdata[1];
      end
      if (bus_wr && bus_addr == 3'd5) begin
        m_en = bus_wdata[0]; m_pm = bus_wdata[1]; m_route = bus_wdata[6:4];
        m_ld = (bus_wdata[2] && bus_wdata[1]) ? 1 : 0;
      end
      m_rdata = nxt_rd;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if ({bus_rdata, irq_legacy, irq_lines} !== {m_rdata, m_irql, m_lines}) begin
        miscompares++;
        $display("FAIL %s: rdata/leg/lines got %h/%b/%b expected %h/%b/%b",
                 cur_req, bus_rdata, irq_legacy, irq_lines, m_rdata, m_irql, m_lines);
      end
      if (irq_legacy) seen_leg++;
      if (|irq_lines) seen_lines++;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    cur_req = "R1";
    chk("R1", {bus_rdata[30:0], irq_legacy}, 32'd0);
    chk("R1", {24'd0, irq_lines}, 32'd0);
    for (int a = 0; a < 8; a++) rd(3'(a));
    rd(3'd6); chk("R1", bus_rdata, 32'hFFFF_FFFF);
    // R2 read-only identity and tick length
    cur_req = "R2";
    rd(3'd0); chk("R2", bus_rdata, 32'h0000_8000);
    rd(3'd1); chk("R2", bus_rdata, 32'(TICK));
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'd5);
    rd(3'd0); chk("R2", bus_rdata, 32'h0000_8000);
    rd(3'd1); chk("R2", bus_rdata, 32'(TICK));
    // R10 upper word and forced 32-bit flag
    cur_req = "R10";
    wr(3'd4, 32'hDEAD_BEEF);
    rd(3'd4); chk("R10", bus_rdata, 32'd0);
    rd(3'd5); chk("R10", bus_rdata & 32'h8, 32'h8);
    // R3 counter run, hold and load
    cur_req = "R3";
    wr(3'd2, 32'd1); idle(10); rd(3'd3);
    wr(3'd2, 32'd0); rd(3'd3); v = bus_rdata;
    idle(5); rd(3'd3); chk("R3", bus_rdata, v);
    wr(3'd3, 32'd100); rd(3'd3); chk("R3", bus_rdata, 32'd100);
    // R4 one-shot match on route 2
    cur_req = "R4";
    wr(3'd3, 32'd0); wr(3'd5, 32'h21); wr(3'd6, 32'd30);
    seen_lines = 0;
    wr(3'd2, 32'd1); idle(40);
    chk("R4", 32'(seen_lines > 0), 32'd1);
    rd(3'd7); chk("R4", bus_rdata, 32'd1);
    cur_req = "R7";
    wr(3'd7, 32'd1); idle(30);
    rd(3'd7); chk("R7", bus_rdata, 32'd0);
    rd(3'd6); chk("R4", bus_rdata, 32'd30);
    // R6 armed load, R5 periodic advance, R7 collisions
    cur_req = "R6";
    wr(3'd2, 32'd0); wr(3'd3, 32'd0); wr(3'd5, 32'h37);
    rd(3'd5); chk("R6", bus_rdata, 32'h3F);
    wr(3'd6, 32'd20);
    rd(3'd5); chk("R6", bus_rdata, 32'h3F);
    wr(3'd6, 32'd12);
    rd(3'd5); chk("R6", bus_rdata, 32'h3B);
    rd(3'd6); chk("R6", bus_rdata, 32'd20);
    cur_req = "R5";
    wr(3'd2, 32'd1);
    cur_req = "R7";
    for (int i = 0; i < 60; i++) wr(3'd7, 32'd1);
    cur_req = "R5";
    idle(30); rd(3'd6); rd(3'd7);
    // R5 wraparound
    wr(3'd2, 32'd0); wr(3'd3, 32'hFFFF_FFF0); wr(3'd5, 32'h37);
    wr(3'd6, 32'hFFFF_FFF8); wr(3'd6, 32'h10);
    wr(3'd2, 32'd1); idle(12); wr(3'd2, 32'd0);
    rd(3'd6); chk("R5", bus_rdata, 32'h8);
    // R8 enable gating, counter keeps running
    cur_req = "R8";
    wr(3'd7, 32'd1); wr(3'd5, 32'h32);
    rd(3'd3); v = bus_rdata;
    seen_lines = 0; seen_leg = 0;
    wr(3'd2, 32'd1); idle(60);
    chk("R8", 32'(seen_lines + seen_leg), 32'd0);
    rd(3'd3); chk("R8", 32'(bus_rdata != v), 32'd1);
    // R9 legacy steering
    cur_req = "R9";
    wr(3'd5, 32'h21); wr(3'd2, 32'd3); wr(3'd7, 32'd1);
    rd(3'd3); v = bus_rdata;
    seen_lines = 0; seen_leg = 0;
    wr(3'd6, v + 32'd30); idle(40);
    chk("R9", 32'(seen_leg > 0), 32'd1);
    chk("R9", 32'(seen_lines), 32'd0);
    wr(3'd2, 32'd1); idle(3);
    chk("R9", {24'd0, irq_lines}, 32'h4);
    chk("R9", {31'd0, irq_legacy}, 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule